// File: doc/BRIEF.md
# PCI Target Address Window Translator

This block sits behind the target side of a PCI interface. It decides whether an inbound 40-bit PCI address belongs to one of its programmable windows. When it does, it claims the access and produces the 36-bit address for the internal system bus. There are three memory windows and one I/O window. A memory window covers a power-of-two region between 1 MB and 512 MB. The I/O window always covers 256 bytes.

Each window holds three settings: a PCI-side base, a system-side base and a control word. A single-cycle register write port loads them. A lookup is offered with a valid strobe, the address and a command-class bit. The result appears one clock later: a valid flag, a hit flag, the index of the winning window, the translated address and the effective byte-swap indication.

Top module: `pci_tgt_xlate`

## Requirements
- R1: A memory-class lookup hits an enabled memory window whose size code selects 2^n bytes when address bits [39:n] equal the window's PCI base bits [39:n]. The translated address is then system base bits [35:n] followed by address bits [n-1:0].
- R2: The size code sits in control bits [31:20]. It is valid only when it is a run of ones from bit 31 down to bit n, with n between 20 (0xFFF, 1 MB) and 29 (0xE00, 512 MB). Any other code makes the window never hit.
- R3: Memory windows answer only lookups with `lkp_is_io`=0. The I/O window answers only lookups with `lkp_is_io`=1.
- R4: The I/O window hits when address bits [31:8] equal its PCI base bits [31:8]. Address bits [39:32] and the I/O window's size code have no effect. The result is I/O system base bits [35:8] followed by address bits [7:0].
- R5: When several memory windows match, the lowest-numbered window is reported. `res_win` is 0 to 2 for the memory windows and 3 for the I/O window.
- R6: A window whose enable bit (control bit 0) is clear never hits.
- R7: `res_valid` and the other results appear exactly one cycle after `lkp_valid` is sampled. When `lkp_valid` was low, `res_valid` is low.
- R8: A register write takes effect on the next cycle. A lookup in the same cycle as a write uses the old settings.
- R9: On a miss, or without a lookup, `res_hit`, `res_win`, `res_addr` and `res_swap` are zero.
- R10: `res_swap` on a hit equals the winning window's swap bit (control bit 2) ANDed with its prefetch bit (control bit 1).
- R11: Register map: `cfg_addr[3:2]` selects the window (3 is the I/O window). `cfg_addr[1:0]` selects the field: 0 is control, 1 is the PCI base (`cfg_wdata[39:0]`) and 2 is the system base (`cfg_wdata[35:0]`). Writes to field 3 are ignored.
- R12: After reset every window is disabled and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: window and field |
| cfg_wdata | input | 40 | Register write data |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_is_io | input | 1 | 1 = I/O-space command, 0 = memory-space command |
| lkp_addr | input | 40 | PCI address to translate |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_hit | output | 1 | A window claimed the access |
| res_win | output | 2 | Index of the claiming window |
| res_addr | output | 36 | Translated system-bus address, zero on a miss |
| res_swap | output | 1 | Effective byte-swap enable of the claiming window |

## Verification
The bench builds the block with its default parameters: three memory windows, 40-bit PCI and 36-bit system addresses, and a 12-bit size code anchored at bit 20. With these values every legal size code from 1 MB to 512 MB can be swept on one window, probing just inside and just outside each boundary. Window overlap across all three memory slots exercises the priority order. A behavioural model, with its settings held in arrays, predicts each cycle's outputs. That prediction includes lookups issued in the same cycle as a write.

// File: rtl/pcix_pkg.sv
package pcix_pkg;

    localparam int PCI_AW    = 40;
    localparam int SYS_AW    = 36;
    localparam int SZ_LSB    = 20;
    localparam int SZ_W      = 12;
    localparam int SZ_MAX_N  = 29;
    localparam int SZ_FIXED  = SZ_LSB + SZ_W - SZ_MAX_N;
    localparam int IO_LSB    = 8;
    localparam int IO_MSB    = 31;
    localparam int CTL_EN    = 0;
    localparam int CTL_PF    = 1;
    localparam int CTL_SW    = 2;

    localparam logic [1:0] FLD_CTRL  = 2'd0;
    localparam logic [1:0] FLD_PBASE = 2'd1;
    localparam logic [1:0] FLD_SBASE = 2'd2;

    typedef struct packed {
        logic              en;
        logic              pf;
        logic              swp;
        logic [SZ_W-1:0]   sz;
        logic [PCI_AW-1:0] pbase;
        logic [SYS_AW-1:0] sbase;
    } win_cfg_t;

endpackage

// File: rtl/pcix_cfg_regs.sv
module pcix_cfg_regs
    import pcix_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [1:0]            fld,
    input  logic [PCI_AW-1:0]     wdata,
    output win_cfg_t [NWIN-1:0]   cfg_o
);

    win_cfg_t [NWIN-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && (int'(sel) < NWIN)) begin
            case (fld)
                FLD_CTRL: begin
                    cfg_d[sel].en  = wdata[CTL_EN];
                    cfg_d[sel].pf  = wdata[CTL_PF];
                    cfg_d[sel].swp = wdata[CTL_SW];
                    cfg_d[sel].sz  = wdata[SZ_LSB +: SZ_W];
                end
                FLD_PBASE: cfg_d[sel].pbase = wdata;
                FLD_SBASE: cfg_d[sel].sbase = wdata[SYS_AW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pcix_mem_match.sv
module pcix_mem_match
    import pcix_pkg::*;
(
    input  win_cfg_t            cfg,
    input  logic                is_mem,
    input  logic [PCI_AW-1:0]   addr,
    output logic                hit,
    output logic [SYS_AW-1:0]   xaddr
);

    localparam int P_TOP = PCI_AW - SZ_LSB - SZ_W;
    localparam int S_TOP = SYS_AW - SZ_LSB - SZ_W;

    logic [SZ_W-1:0]   sz_inv;
    logic              sz_thermo;
    logic              sz_fixed_ok;
    logic              sz_ok;
    logic [PCI_AW-1:0] pmask;
    logic [SYS_AW-1:0] smask;

    always_comb begin
        sz_inv      = ~cfg.sz;
        sz_thermo   = ((sz_inv & (sz_inv + SZ_W'(1))) == '0);
        sz_fixed_ok = &cfg.sz[SZ_W-1 -: SZ_FIXED];
        sz_ok       = sz_thermo && sz_fixed_ok;
        pmask       = {{P_TOP{1'b1}}, cfg.sz, {SZ_LSB{1'b0}}};
        smask       = {{S_TOP{1'b1}}, cfg.sz, {SZ_LSB{1'b0}}};
        hit         = cfg.en && sz_ok && is_mem
                      && (((addr ^ cfg.pbase) & pmask) == '0);
        xaddr       = (cfg.sbase & smask) | (addr[SYS_AW-1:0] & ~smask);
    end

endmodule

// File: rtl/pcix_io_match.sv
module pcix_io_match
    import pcix_pkg::*;
(
    input  logic                    en,
    input  logic                    is_io,
    input  logic [IO_MSB:IO_LSB]    pbase_cmp,
    input  logic [SYS_AW-1:IO_LSB]  sbase_hi,
    input  logic [IO_MSB:0]         addr,
    output logic                    hit,
    output logic [SYS_AW-1:0]       xaddr
);

    always_comb begin
        hit   = en && is_io && (addr[IO_MSB:IO_LSB] == pbase_cmp);
        xaddr = {sbase_hi, addr[IO_LSB-1:0]};
    end

endmodule

// File: rtl/pci_tgt_xlate.sv
module pci_tgt_xlate
    import pcix_pkg::*;
#(
    parameter int NUM_MEM_WIN = 3,
    localparam int NWIN  = NUM_MEM_WIN + 1,
    localparam int WIN_W = $clog2(NWIN),
    localparam int CFG_AW = WIN_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [PCI_AW-1:0]   cfg_wdata,
    input  logic                lkp_valid,
    input  logic                lkp_is_io,
    input  logic [PCI_AW-1:0]   lkp_addr,
    output logic                res_valid,
    output logic                res_hit,
    output logic [WIN_W-1:0]    res_win,
    output logic [SYS_AW-1:0]   res_addr,
    output logic                res_swap
);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [SYS_AW-1:0] addr;
        logic              swp;
    } res_t;

    win_cfg_t [NWIN-1:0]        cfg;
    logic [NUM_MEM_WIN-1:0]     mem_hit;
    logic [SYS_AW-1:0]          mem_xaddr [NUM_MEM_WIN];
    logic                       io_hit;
    logic [SYS_AW-1:0]          io_xaddr;
    res_t                       res_d, res_q;

    pcix_cfg_regs #(.NWIN(NWIN)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_addr[CFG_AW-1:2]),
        .fld   (cfg_addr[1:0]),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
        pcix_mem_match i_match (
            .cfg    (cfg[w]),
            .is_mem (~lkp_is_io),
            .addr   (lkp_addr),
            .hit    (mem_hit[w]),
            .xaddr  (mem_xaddr[w])
        );
    end

    pcix_io_match i_io (
        .en        (cfg[NUM_MEM_WIN].en),
        .is_io     (lkp_is_io),
        .pbase_cmp (cfg[NUM_MEM_WIN].pbase[IO_MSB:IO_LSB]),
        .sbase_hi  (cfg[NUM_MEM_WIN].sbase[SYS_AW-1:IO_LSB]),
        .addr      (lkp_addr[IO_MSB:0]),
        .hit       (io_hit),
        .xaddr     (io_xaddr)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = lkp_valid;
        if (lkp_valid) begin
            if (io_hit) begin
                res_d.hit  = 1'b1;
                res_d.win  = WIN_W'(NUM_MEM_WIN);
                res_d.addr = io_xaddr;
                res_d.swp  = cfg[NUM_MEM_WIN].pf & cfg[NUM_MEM_WIN].swp;
            end
            for (int w = NUM_MEM_WIN - 1; w >= 0; w--) begin
                if (mem_hit[w]) begin
                    res_d.hit  = 1'b1;
                    res_d.win  = WIN_W'(w);
                    res_d.addr = mem_xaddr[w];
                    res_d.swp  = cfg[w].pf & cfg[w].swp;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_win   = res_q.win;
    assign res_addr  = res_q.addr;
    assign res_swap  = res_q.swp;

endmodule

// File: rtl/pcix_xlate_chk.sv
module pcix_xlate_chk #(
    parameter int NUM_MEM_WIN = 3,
    parameter int WIN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lkp_valid,
    input logic              lkp_is_io,
    input logic [39:0]       lkp_addr,
    input logic              res_valid,
    input logic              res_hit,
    input logic [WIN_W-1:0]  res_win,
    input logic [35:0]       res_addr,
    input logic              res_swap
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lkp_valid |=> res_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !lkp_valid |=> !res_valid); // R7
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) res_hit |-> res_valid); // R9
    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !res_hit |-> (res_addr == '0 && res_win == '0)); // R9
    AST_SWAP_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) res_swap |-> res_hit); // R10
    AST_IO_CMD_IO_WIN: assert property (@(posedge clk) disable iff (!rst_n) (lkp_valid && lkp_is_io) |=> (!res_hit || res_win == WIN_W'(NUM_MEM_WIN))); // R3
    AST_MEM_CMD_MEM_WIN: assert property (@(posedge clk) disable iff (!rst_n) (lkp_valid && !lkp_is_io) |=> (!res_hit || res_win < WIN_W'(NUM_MEM_WIN))); // R3
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lkp_valid |=> (!res_hit || res_addr[7:0] == $past(lkp_addr[7:0]))); // R1

endmodule

bind pci_tgt_xlate pcix_xlate_chk #(.NUM_MEM_WIN(NUM_MEM_WIN), .WIN_W(WIN_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_is_io (lkp_is_io),
    .lkp_addr  (lkp_addr),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_win   (res_win),
    .res_addr  (res_addr),
    .res_swap  (res_swap)
);

// File: tb/test_pci_tgt_xlate.sv
`timescale 1ns/1ps
module test_pci_tgt_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [39:0] cfg_wdata = '0;
    logic        lkp_valid = 1'b0;
    logic        lkp_is_io = 1'b0;
    logic [39:0] lkp_addr = '0;
    logic        res_valid, res_hit, res_swap;
    logic [1:0]  res_win;
    logic [35:0] res_addr;

    int n_checks = 0;
    int n_fail = 0;

    // model settings
    logic        m_en [4];
    logic        m_pf [4];
    logic        m_sw [4];
    logic [11:0] m_sz [4];
    logic [39:0] m_pb [4];
    logic [35:0] m_sb [4];

    logic        e_vld = 0, e_hit = 0, e_sw = 0;
    logic [1:0]  e_win = 0;
    logic [35:0] e_addr = 0;
    string       e_tag = "R12";

    always #2.5 clk = ~clk;

    pci_tgt_xlate i_pci_tgt_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lkp_valid(lkp_valid), .lkp_is_io(lkp_is_io),
        .lkp_addr(lkp_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_win(res_win), .res_addr(res_addr), .res_swap(res_swap)
    );

    function automatic logic [11:0] code_for(input int n);
        return 12'((12'hFFF << (n - 20)));
    endfunction

    task automatic predict(input logic v, input logic io, input logic [39:0] a);
        logic [63:0] aw, pw, sw, lo;
        e_vld = v; e_hit = 0; e_win = 0; e_addr = 0; e_sw = 0;
        if (!v) return;
        if (!io) begin
            for (int w = 0; w < 3; w++) begin
                int nn = 0;
                for (int n = 20; n <= 29; n++) if (m_sz[w] == code_for(n)) nn = n;
                aw = 64'(a); pw = 64'(m_pb[w]); sw = 64'(m_sb[w]);
                if (!e_hit && m_en[w] && nn != 0 && (aw >> nn) == (pw >> nn)) begin
                    lo = (64'd1 << nn) - 1;
                    e_hit = 1; e_win = 2'(w);
                    e_addr = 36'((sw & ~lo) | (aw & lo));
                    e_sw = m_pf[w] & m_sw[w];
                end
            end
        end else if (m_en[3] && a[31:8] == m_pb[3][31:8]) begin
            e_hit = 1; e_win = 2'd3;
            e_addr = {m_sb[3][35:8], a[7:0]};
            e_sw = m_pf[3] & m_sw[3];
        end
    endtask

    task automatic step(input logic v, input logic io, input logic [39:0] a,
                        input logic we, input logic [3:0] wa, input logic [39:0] wd,
                        input string tag);
        int sel;
        @(negedge clk);
        n_checks++;
        if (res_valid !== e_vld || res_hit !== e_hit || res_win !== e_win ||
            res_addr !== e_addr || res_swap !== e_sw) begin
            n_fail++;
            $display("FAIL %s: actual vld=%b hit=%b win=%0d addr=%h swap=%b expected vld=%b hit=%b win=%0d addr=%h swap=%b",
                     e_tag, res_valid, res_hit, res_win, res_addr, res_swap,
                     e_vld, e_hit, e_win, e_addr, e_sw);
        end
        predict(v, io, a);
        e_tag = tag;
        if (we) begin
            sel = int'(wa[3:2]);
            case (wa[1:0])
                2'd0: begin
                    m_en[sel] = wd[0]; m_pf[sel] = wd[1];
                    m_sw[sel] = wd[2]; m_sz[sel] = wd[31:20];
                end
                2'd1: m_pb[sel] = wd;
                2'd2: m_sb[sel] = wd[35:0];
                default: ;
            endcase
        end
        lkp_valid = v; lkp_is_io = io; lkp_addr = a;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    endtask

    task automatic wr(input logic [3:0] wa, input logic [39:0] wd, input string tag);
        step(0, 0, '0, 1, wa, wd, tag);
    endtask

    task automatic lk(input logic io, input logic [39:0] a, input string tag);
        step(1, io, a, 0, '0, '0, tag);
    endtask

    function automatic logic [39:0] ctl(input logic [11:0] sz, input logic sw,
                                         input logic pf, input logic en);
        return {8'h0, sz, 17'h0, sw, pf, en};
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_pf[i] = 0; m_sw[i] = 0; m_sz[i] = 0; m_pb[i] = 0; m_sb[i] = 0;
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R12: reset values, all windows disabled
        step(0, 0, '0, 0, '0, '0, "R12");
        lk(0, 40'h00_0000_0000, "R12");
        lk(1, 40'h00_0000_0000, "R12");

        // R11 / R1: window 0, 1 MB
        wr(4'h1, 40'h12_3450_0000, "R11");
        wr(4'h2, 40'h08_A000_0000, "R11");
        wr(4'h0, ctl(12'hFFF, 0, 0, 1), "R11");
        lk(0, 40'h12_345A_BCDE, "R1");
        lk(0, 40'h12_3460_0000, "R1");
        lk(0, 40'h12_344F_FFFF, "R9");
        step(0, 0, '0, 0, '0, '0, "R7");

        // R8: disable in same cycle as a hitting lookup
        step(1, 0, 40'h12_3450_0010, 1, 4'h0, ctl(12'hFFF, 0, 0, 0), "R8");
        lk(0, 40'h12_3450_0010, "R6");
        wr(4'h0, ctl(12'hFFF, 0, 0, 1), "R8");
        lk(0, 40'h12_3450_0010, "R8");

        // R2: every legal size on window 1
        wr(4'h5, 40'h05_6000_0000, "R11");
        wr(4'h6, 40'h0A_5A5A_5A5A, "R11");
        for (int n = 20; n <= 29; n++) begin
            wr(4'h4, ctl(code_for(n), 1, 1, 1), "R2");
            lk(0, 40'h05_6000_0000 | 40'((64'd1 << n) - 1), "R2");
            lk(0, 40'h05_6000_0000 ^ 40'((64'd1 << n)), "R2");
            lk(0, 40'h05_6000_0000 | 40'h0000_0ABC, "R2");
        end
        // R2: malformed codes
        wr(4'h4, ctl(12'hF0F, 1, 1, 1), "R2");
        lk(0, 40'h05_6000_0123, "R2");
        wr(4'h4, ctl(12'h7FF, 1, 1, 1), "R2");
        lk(0, 40'h05_6000_0123, "R2");
        wr(4'h4, ctl(12'hEFF, 1, 1, 1), "R2");
        lk(0, 40'h05_6000_0123, "R2");
        wr(4'h4, ctl(12'h000, 1, 1, 1), "R2");
        lk(0, 40'h05_6000_0123, "R2");

        // R10: swap only with prefetch
        wr(4'h4, ctl(12'hFFF, 1, 0, 1), "R10");
        lk(0, 40'h05_6000_0123, "R10");
        wr(4'h4, ctl(12'hFFF, 0, 1, 1), "R10");
        lk(0, 40'h05_6000_0123, "R10");
        wr(4'h4, ctl(12'hFFF, 1, 1, 1), "R10");
        lk(0, 40'h05_6000_0123, "R10");

        // R11: field 3 writes ignored
        wr(4'h7, 40'hFF_FFFF_FFFF, "R11");
        lk(0, 40'h05_6000_0123, "R11");

        // R5: overlapping windows
        wr(4'h9, 40'h12_3450_0000, "R5");
        wr(4'hA, 40'h03_0000_0000, "R5");
        wr(4'h8, ctl(12'hFFF, 0, 0, 1), "R5");
        wr(4'h5, 40'h12_2000_0000, "R5");
        wr(4'h4, ctl(12'hE00, 1, 1, 1), "R5");
        lk(0, 40'h12_3450_4444, "R5");
        wr(4'h0, ctl(12'hFFF, 0, 0, 0), "R5");
        lk(0, 40'h12_3450_4444, "R5");
        wr(4'h4, ctl(12'hE00, 1, 1, 0), "R6");
        lk(0, 40'h12_3450_4444, "R5");
        lk(0, 40'h12_2000_0001, "R6");

        // R4 / R3: I/O window
        wr(4'hD, 40'h00_ABCD_1200, "R4");
        wr(4'hE, 40'h0F_0000_0000, "R4");
        wr(4'hC, ctl(12'h000, 1, 1, 1), "R4");
        lk(1, 40'hFF_ABCD_1234, "R4");
        lk(1, 40'h00_ABCD_12FF, "R4");
        lk(1, 40'h00_ABCD_1334, "R4");
        lk(0, 40'h00_ABCD_1234, "R3");
        lk(1, 40'h12_3450_4444, "R3");
        wr(4'h8, ctl(12'hFFF, 0, 0, 1), "R3");
        lk(1, 40'h12_3450_4444, "R3");
        lk(0, 40'h12_3450_4444, "R3");
        wr(4'hC, ctl(12'h000, 1, 1, 0), "R6");
        lk(1, 40'h00_ABCD_1234, "R6");
        step(0, 0, '0, 0, '0, '0, "R7");
        step(0, 0, '0, 0, '0, '0, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule